// File: doc/BRIEF.md
# Magnetic Memory Write Pulse Sequencer

This controller turns one write request into the ordered set of enables a magnetic tunnel junction array needs to write one cell. It first grounds the selected bit-line path by turning on the column decoder and one current sink, then starts the word-line current, and a programmable number of cycles later starts the bit-line current. The current sources then turn off, and the sink and decoder are released one cycle later. Every duration is a cycle count taken from configuration inputs when the request is accepted.

The bit-line current direction is chosen by which of two diagonal source/sink pairs is enabled. In direct-write mode the data bit picks the pair. In toggle mode a cell flips on every pulse sequence, so the controller first raises the read word line and waits for the stored bit. It issues the pulses, always with the same pair, only when the stored bit differs from the new data. Otherwise it finishes without driving any current.

Top module: `mram_wr_seq`

## Requirements
- R1: While reset is asserted, and on the cycle after reset is taken mid-write, every enable, `busy` and `done` are low.
- R2: After acceptance (and after the read in toggle mode), `col_dec_en` and the chosen sink are on for `cfg_dis` cycles before `wl_src_en` rises; a value of 0 counts as 1.
- R3: `wl_src_en` is high for exactly `cfg_wl` cycles (0 counts as 1).
- R4: The bit-line source rises `lead` cycles after `wl_src_en` rises, where `lead` is `cfg_lead` with 0 taken as 1 and capped at the effective word-line width; it stays high for `cfg_bl` cycles (0 counts as 1).
- R5: In direct-write mode (`toggle_mode`=0), data 1 uses `src_a_en`/`sink_a_en` and data 0 uses `src_b_en`/`sink_b_en`; the other pair stays low for the whole write.
- R6: In toggle mode, `rwl_en` is held high until `rd_valid`; the pulse sequence then starts the next cycle only if `rd_bit` differs from the data, and it always uses pair A.
- R7: A toggle-mode write whose stored bit already matches drives no current enable and raises `done` two cycles after the last `rwl_en` cycle.
- R8: `rwl_en` is never high in the same cycle as any current or path enable, and never rises in direct-write mode.
- R9: The sink and `col_dec_en` stay on for exactly one cycle after the last cycle in which a current source is on, then drop.
- R10: `done` is a single-cycle pulse raised two cycles after the last path-enable cycle, leaving one cycle with all enables low in between.
- R11: While `busy`, new requests and changes on data, mode, address and configuration inputs have no effect on the write in progress.
- R12: `arr_addr` holds the accepted address for every cycle that `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, accepted when idle |
| wr_addr | input | AW | Cell address |
| wr_data | input | 1 | Bit to write |
| toggle_mode | input | 1 | 1 = toggle cell, 0 = direct-write cell |
| cfg_dis | input | CW | Discharge length in cycles |
| cfg_lead | input | CW | Word-line to bit-line start offset in cycles |
| cfg_wl | input | CW | Word-line pulse width in cycles |
| cfg_bl | input | CW | Bit-line pulse width in cycles |
| rd_valid | input | 1 | Stored bit is valid (toggle mode) |
| rd_bit | input | 1 | Stored bit read from the cell |
| busy | output | 1 | A write is in progress |
| arr_addr | output | AW | Latched address for the array decoders |
| col_dec_en | output | 1 | Column decoder enable |
| sink_a_en | output | 1 | Bit-line sink of pair A |
| sink_b_en | output | 1 | Bit-line sink of pair B |
| src_a_en | output | 1 | Bit-line source of pair A |
| src_b_en | output | 1 | Bit-line source of pair B |
| wl_src_en | output | 1 | Word-line current source enable |
| rwl_en | output | 1 | Read word-line enable |
| done | output | 1 | Write-complete strobe |

## Verification
Direct-write patterns with both data values separate the two source/sink pairs, and varied counts with the offset shorter than, equal to and longer than the word-line width check each timing window and the cap on the offset. All-zero and all-one counts check the minimum sequence. Toggle patterns cover all four combinations of stored and new bit, which separates the compare-then-pulse path from the skip path. A write that has new requests and changed inputs driven throughout, and a reset taken during the pulse phase, check latching and recovery.

// File: rtl/mram_wr_pkg.sv
package mram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_DISCH = 3'd2,
    ST_PULSE = 3'd3,
    ST_TAIL  = 3'd4,
    ST_FIN   = 3'd5,
    ST_DONE  = 3'd6
  } wr_state_e;

endpackage

// File: rtl/mram_wr_fsm.sv
module mram_wr_fsm
  import mram_wr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic          toggle_mode,
  input  logic          rd_valid,
  input  logic          rd_bit,
  input  logic          dis_last,
  input  logic          pulse_last,
  output wr_state_e     state,
  output logic          accept,
  output logic          data_q,
  output logic          tog_q,
  output logic [AW-1:0] addr_q
);

  wr_state_e state_d;
  logic      need_flip;

  assign accept    = (state == ST_IDLE) && wr_req;
  assign need_flip = rd_bit != data_q;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (wr_req) state_d = toggle_mode ? ST_READ : ST_DISCH;
      ST_READ:  if (rd_valid) state_d = need_flip ? ST_DISCH : ST_FIN;
      ST_DISCH: if (dis_last) state_d = ST_PULSE;
      ST_PULSE: if (pulse_last) state_d = ST_TAIL;
      ST_TAIL:  state_d = ST_FIN;
      ST_FIN:   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= 1'b0;
      tog_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      state <= state_d;
      if (accept) begin
        data_q <= wr_data;
        tog_q  <= toggle_mode;
        addr_q <= wr_addr;
      end
    end
  end

  // R6: the read phase is only entered for toggle-mode requests
  a_r6_read_only_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wr_req) |=> (state == ST_READ) == tog_q);

  // R11: latched write data stays fixed for the whole write
  a_r11_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(data_q) && $stable(tog_q));

endmodule

// File: rtl/mram_pulse_timer.sv
module mram_pulse_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cfg_dis,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_wl,
  input  logic [CW-1:0] cfg_bl,
  input  logic          in_dis,
  input  logic          in_pulse,
  output logic          dis_last,
  output logic          pulse_last,
  output logic          wl_win,
  output logic          bl_win
);

  localparam int CNTW = CW + 1;

  // zero length is raised to one cycle
  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  // the bit-line start is at least one cycle after the word line and
  // no later than the end of the word-line pulse
  function automatic logic [CW-1:0] clamp_lead(input logic [CW-1:0] lead,
                                               input logic [CW-1:0] wl_eff);
    logic [CW-1:0] l;
    l = at_least_one(lead);
    return (l > wl_eff) ? wl_eff : l;
  endfunction

  function automatic logic [CNTW-1:0] pulse_span(input logic [CW-1:0] wl_eff,
                                                 input logic [CW-1:0] lead_eff,
                                                 input logic [CW-1:0] bl_eff);
    logic [CNTW-1:0] a, b;
    a = CNTW'(wl_eff);
    b = CNTW'(lead_eff) + CNTW'(bl_eff);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0]   dis_q, wl_q, lead_q, bl_q;
  logic [CNTW-1:0] span_q, cnt_q;
  logic [CW-1:0]   wl_new, lead_new, bl_new;

  assign wl_new   = at_least_one(cfg_wl);
  assign lead_new = clamp_lead(cfg_lead, wl_new);
  assign bl_new   = at_least_one(cfg_bl);

  assign dis_last   = in_dis   && (cnt_q == CNTW'(dis_q) - CNTW'(1));
  assign pulse_last = in_pulse && (cnt_q == span_q - CNTW'(1));
  assign wl_win     = in_pulse && (cnt_q < CNTW'(wl_q));
  assign bl_win     = in_pulse && (cnt_q >= CNTW'(lead_q)) &&
                      (cnt_q < CNTW'(lead_q) + CNTW'(bl_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= CW'(1);
      wl_q   <= CW'(1);
      lead_q <= CW'(1);
      bl_q   <= CW'(1);
      span_q <= CNTW'(2);
      cnt_q  <= '0;
    end else begin
      if (load) begin
        dis_q  <= at_least_one(cfg_dis);
        wl_q   <= wl_new;
        lead_q <= lead_new;
        bl_q   <= bl_new;
        span_q <= pulse_span(wl_new, lead_new, bl_new);
      end
      if (dis_last || pulse_last || !(in_dis || in_pulse)) cnt_q <= '0;
      else                                                 cnt_q <= cnt_q + CNTW'(1);
    end
  end

  // R4: bit-line window opens only while the word line was already on
  a_r4_wl_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_win) |-> $past(wl_win));

  // R3: word-line window opens at the first pulse-phase cycle
  a_r3_wl_opens_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse && !$past(in_pulse)) |-> wl_win && !bl_win);

endmodule

// File: rtl/mram_bl_steer.sv
module mram_bl_steer #(
  parameter bit TOG_PAIR_A = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic path_on,
  input  logic bl_win,
  input  logic data_q,
  input  logic tog_q,
  output logic sink_a_en,
  output logic sink_b_en,
  output logic src_a_en,
  output logic src_b_en
);

  logic use_a;

  // toggle cells always use one fixed pair; direct-write data selects it
  generate
    if (TOG_PAIR_A) begin : g_tog_a
      assign use_a = tog_q | data_q;
    end else begin : g_tog_b
      assign use_a = !tog_q & data_q;
    end
  endgenerate

  assign sink_a_en = path_on &  use_a;
  assign sink_b_en = path_on & !use_a;
  assign src_a_en  = bl_win  &  use_a;
  assign src_b_en  = bl_win  & !use_a;

  // R5: at most one diagonal pair is ever active
  a_r5_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !((sink_a_en || src_a_en) && (sink_b_en || src_b_en)));

  // R2: a source is only on with its own sink
  a_r2_src_has_sink: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_en |-> sink_a_en) and (src_b_en |-> sink_b_en));

endmodule

// File: rtl/mram_wr_seq.sv
module mram_wr_seq
  import mram_wr_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic          toggle_mode,
  input  logic [CW-1:0] cfg_dis,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_wl,
  input  logic [CW-1:0] cfg_bl,
  input  logic          rd_valid,
  input  logic          rd_bit,
  output logic          busy,
  output logic [AW-1:0] arr_addr,
  output logic          col_dec_en,
  output logic          sink_a_en,
  output logic          sink_b_en,
  output logic          src_a_en,
  output logic          src_b_en,
  output logic          wl_src_en,
  output logic          rwl_en,
  output logic          done
);

  wr_state_e state;
  logic      accept, data_q, tog_q;
  logic      dis_last, pulse_last, wl_win, bl_win;
  logic      in_dis, in_pulse, path_on;

  assign in_dis   = state == ST_DISCH;
  assign in_pulse = state == ST_PULSE;
  assign path_on  = in_dis || in_pulse || (state == ST_TAIL);

  mram_wr_fsm #(.AW(AW)) u_fsm (
    .clk, .rst_n, .wr_req, .wr_addr, .wr_data, .toggle_mode,
    .rd_valid, .rd_bit, .dis_last, .pulse_last,
    .state, .accept, .data_q, .tog_q, .addr_q(arr_addr)
  );

  mram_pulse_timer #(.CW(CW)) u_timer (
    .clk, .rst_n, .load(accept),
    .cfg_dis, .cfg_lead, .cfg_wl, .cfg_bl,
    .in_dis, .in_pulse,
    .dis_last, .pulse_last, .wl_win, .bl_win
  );

  mram_bl_steer #(.TOG_PAIR_A(1'b1)) u_steer (
    .clk, .rst_n, .path_on, .bl_win, .data_q, .tog_q,
    .sink_a_en, .sink_b_en, .src_a_en, .src_b_en
  );

  assign busy       = state != ST_IDLE;
  assign col_dec_en = path_on;
  assign wl_src_en  = wl_win;
  assign rwl_en     = state == ST_READ;
  assign done       = state == ST_DONE;

  // R8: read word line excludes every write enable
  a_r8_rwl_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rwl_en |-> !(col_dec_en || sink_a_en || sink_b_en || src_a_en || src_b_en || wl_src_en));

  // R2: word-line current only starts after a discharge cycle
  a_r2_discharge_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_src_en) |-> $past(col_dec_en) && $past(sink_a_en || sink_b_en));

  // R9: path released only once all sources were off
  a_r9_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_dec_en) |-> $past(!(src_a_en || src_b_en || wl_src_en)));

  // R10: done follows a cycle with every enable low
  a_r10_done_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!col_dec_en && !rwl_en) && !col_dec_en);

  // R12: address stable while busy
  a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr));

endmodule

// File: tb/mram_wr_seq_bench.sv
`timescale 1ns/1ps
module mram_wr_seq_bench;

  localparam int AW = 10;
  localparam int CW = 6;

  typedef struct packed {
    logic          tog;
    logic          data;
    logic          stored;
    logic [CW-1:0] dis;
    logic [CW-1:0] lead;
    logic [CW-1:0] wl;
    logic [CW-1:0] bl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 6'd2, 6'd2, 6'd5, 6'd4},
    '{1'b0, 1'b0, 1'b0, 6'd3, 6'd1, 6'd3, 6'd3},
    '{1'b0, 1'b1, 1'b0, 6'd1, 6'd1, 6'd1, 6'd1},
    '{1'b0, 1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 6'd0},
    '{1'b0, 1'b1, 1'b0, 6'd2, 6'd6, 6'd3, 6'd2},
    '{1'b1, 1'b1, 1'b0, 6'd2, 6'd2, 6'd4, 6'd3},
    '{1'b1, 1'b0, 1'b1, 6'd1, 6'd1, 6'd2, 6'd5},
    '{1'b1, 1'b1, 1'b1, 6'd2, 6'd2, 6'd4, 6'd3},
    '{1'b1, 1'b0, 1'b0, 6'd2, 6'd2, 6'd4, 6'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_data = 1'b0;
  logic          toggle_mode = 1'b0;
  logic [CW-1:0] cfg_dis = '0, cfg_lead = '0, cfg_wl = '0, cfg_bl = '0;
  logic          rd_valid = 1'b0;
  logic          rd_bit = 1'b0;
  logic          busy, col_dec_en, sink_a_en, sink_b_en, src_a_en, src_b_en;
  logic          wl_src_en, rwl_en, done;
  logic [AW-1:0] arr_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mram_wr_seq #(.AW(AW), .CW(CW)) u_mram_wr_seq (
    .clk, .rst_n, .wr_req, .wr_addr, .wr_data, .toggle_mode,
    .cfg_dis, .cfg_lead, .cfg_wl, .cfg_bl, .rd_valid, .rd_bit,
    .busy, .arr_addr, .col_dec_en, .sink_a_en, .sink_b_en,
    .src_a_en, .src_b_en, .wl_src_en, .rwl_en, .done
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int lead_of(input int l, input int w);
    int a = eff(l);
    int b = eff(w);
    return (a < b) ? a : b;
  endfunction

  function automatic logic all_low();
    return !(busy || col_dec_en || sink_a_en || sink_b_en || src_a_en ||
             src_b_en || wl_src_en || rwl_en || done);
  endfunction

  task automatic run_write(input vec_t v, input bit noise, input logic [AW-1:0] addr);
    int dec_f = -1, dec_l = -1, dec_n = 0;
    int wl_f = -1, wl_l = -1, wl_n = 0;
    int src_f = -1, src_l = -1, src_n = 0;
    int sa_n = 0, sb_n = 0, pa_n = 0, pb_n = 0;
    int rwl_l = -1, rwl_n = 0, rwl_age = 0;
    int done_f = -1, done_n = 0, ovl = 0, addr_bad = 0, tail = -1;
    bit pulse, use_a;
    int dis_e, wl_e, ld_e, bl_e, last_src;
    @(negedge clk);
    wr_req = 1'b1; wr_addr = addr; wr_data = v.data; toggle_mode = v.tog;
    cfg_dis = v.dis; cfg_lead = v.lead; cfg_wl = v.wl; cfg_bl = v.bl;
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      if (!noise || done_n > 0 || done) wr_req = 1'b0;
      if (noise) begin
        wr_data = ~v.data; toggle_mode = ~v.tog; wr_addr = ~addr;
        cfg_wl = v.wl + 6'd3; cfg_dis = v.dis + 6'd2;
      end
      if (col_dec_en) begin if (dec_f < 0) dec_f = c; dec_l = c; dec_n++; end
      if (wl_src_en)  begin if (wl_f < 0) wl_f = c; wl_l = c; wl_n++; end
      if (src_a_en || src_b_en) begin if (src_f < 0) src_f = c; src_l = c; src_n++; end
      if (sink_a_en) sa_n++;
      if (sink_b_en) sb_n++;
      if (src_a_en)  pa_n++;
      if (src_b_en)  pb_n++;
      if (rwl_en && (col_dec_en || sink_a_en || sink_b_en || wl_src_en || src_a_en || src_b_en)) ovl++;
      if (busy && arr_addr != addr) addr_bad++;
      if (done) begin if (done_f < 0) done_f = c; done_n++; end
      rd_valid = 1'b0;
      if (rwl_en) begin
        rwl_l = c; rwl_n++; rwl_age++;
        if (rwl_age == 2) begin rd_valid = 1'b1; rd_bit = v.stored; end
      end
      if (done_f >= 0 && tail < 0) tail = c + 3;
      if (c == tail) break;
    end
    wr_req = 1'b0;
    pulse = !v.tog || (v.stored != v.data);
    use_a = v.tog || v.data;
    dis_e = eff(int'(v.dis)); wl_e = eff(int'(v.wl));
    ld_e = lead_of(int'(v.lead), int'(v.wl)); bl_e = eff(int'(v.bl));
    chk(done_n == 1, "R10 done pulse count", done_n, 1);
    chk(ovl == 0, "R8 rwl overlap", ovl, 0);
    chk(addr_bad == 0, "R12 addr held", addr_bad, 0);
    if (!v.tog) chk(rwl_n == 0, "R8 rwl in direct mode", rwl_n, 0);
    if (pulse) begin
      last_src = (wl_l > src_l) ? wl_l : src_l;
      chk(wl_f - dec_f == dis_e, "R2 discharge length", wl_f - dec_f, dis_e);
      chk(wl_n == wl_e, "R3 wl width", wl_n, wl_e);
      chk(src_f - wl_f == ld_e, "R4 bl lead", src_f - wl_f, ld_e);
      chk(src_n == bl_e, "R4 bl width", src_n, bl_e);
      chk(dec_l - last_src == 1, "R9 release lag", dec_l - last_src, 1);
      chk(done_f - dec_l == 2, "R10 done delay", done_f - dec_l, 2);
      if (use_a) begin
        chk(sa_n == dec_n && pa_n == bl_e, "R5 pair A used", sa_n, dec_n);
        chk(sb_n == 0 && pb_n == 0, "R5 pair B idle", sb_n + pb_n, 0);
      end else begin
        chk(sb_n == dec_n && pb_n == bl_e, "R5 pair B used", sb_n, dec_n);
        chk(sa_n == 0 && pa_n == 0, "R5 pair A idle", sa_n + pa_n, 0);
      end
      if (v.tog) begin
        chk(dec_f - rwl_l == 1, "R6 pulse after compare", dec_f - rwl_l, 1);
        chk(pb_n == 0 && sb_n == 0, "R6 toggle single pair", pb_n + sb_n, 0);
      end
    end else begin
      chk(dec_n + wl_n + src_n + sa_n + sb_n == 0, "R7 skip no current",
          dec_n + wl_n + src_n + sa_n + sb_n, 0);
      chk(done_f - rwl_l == 2, "R7 skip done delay", done_f - rwl_l, 2);
    end
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(all_low(), "R1 outputs in reset", int'(!all_low()), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(all_low(), "R1 outputs after reset", int'(!all_low()), 0);

    for (int i = 0; i < NV; i++) run_write(VECS[i], 1'b0, AW'(37 * i + 5));

    // R11: requests and input changes during a write are ignored
    run_write(VECS[0], 1'b1, AW'(10'h155));
    run_write(VECS[5], 1'b1, AW'(10'h2AA));

    // R1: reset taken in the middle of a pulse
    @(negedge clk);
    wr_req = 1'b1; wr_data = 1'b1; toggle_mode = 1'b0;
    cfg_dis = 6'd2; cfg_lead = 6'd2; cfg_wl = 6'd8; cfg_bl = 6'd5;
    @(negedge clk); wr_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(wl_src_en == 1'b1, "R3 wl on before reset", int'(wl_src_en), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(all_low(), "R1 outputs after mid-write reset", int'(!all_low()), 0);
    rst_n = 1'b1;
    run_write(VECS[1], 1'b0, AW'(3));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule